// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is an 8-bit synchronous serial port for a small microcontroller. One shift register serves both directions. During a transfer, the least significant bit leaves on the serial output first. At the same time, bits arriving on the serial input enter at the top and move down, so after eight bits the register holds the received byte with its first bit at bit 0. New output data is driven on each falling edge of the shift clock. Input data is captured on each rising edge.

The shift clock comes from one of two places. It can be made inside the block from an instruction-clock enable pulse, divided by 2, 4 or 8. In that case the block drives exactly eight pulses on its clock pin and leaves the pin high between transfers. Otherwise it is taken from the clock pin as an input. That external clock passes through a two-flop synchronizer and an edge detector before it reaches the shift logic. The external clock must run no faster than a quarter of the system clock.

The processor writes the register as two 4-bit halves and reads it the same way. It selects the clock with a 2-bit control field and starts a transfer with a one-cycle strobe. When the eighth bit has been taken in, a completion flag rises. This flag can serve as an interrupt request.

Top module: `sio_port`

## Requirements
- R1: After reset the shift register reads 0, the completion flag is 0, the clock output is 1, the control field is 00 (external clock) and the serial output is 1.
- R2: Transmit order is least significant bit first. The value on `sout_o` at the k-th rising shift-clock edge is bit k-1 of the byte held when the transfer started.
- R3: `sout_o` changes only in the system-clock cycle in which the shift clock falls.
- R4: Receive order is least significant bit first. At each rising shift-clock edge the register shifts right and `sin_i` enters at bit 7, so after eight edges the first received bit sits at bit 0.
- R5: In internal mode, a transfer drives exactly eight low pulses on `sck_o`. `sck_o` is 1 whenever no transfer is in progress.
- R6: The control field `ctl_rate_i` uses these codes: 01 gives instruction clock divided by 2, 10 gives divided by 4, 11 gives divided by 8. Each shift-clock phase, high or low, lasts 1, 2 or 4 `instck_en_i` pulses respectively.
- R7: Code 00 selects the external clock. In this mode `sck_oe_o` is 0, and the edges of `sck_i` (after synchronization) time both shifting and capture.
- R8: `done_o` rises in the cycle after the eighth rising edge is handled. It then stays 1 until `flag_clr_i` is asserted or an accepted `start_i` arrives, and either of these clears it.
- R9: If `flag_clr_i` is asserted in the same cycle as the eighth rising edge, the completion flag is still set.
- R10: While a transfer is in progress, `start_i`, `ctl_wr_i`, `wr_lo_i` and `wr_hi_i` are ignored: the bit count, the clock rate and the register contents are unaffected.
- R11: `wr_lo_i` writes `wdata_i` into register bits 3..0 and `wr_hi_i` writes it into bits 7..4. `sreg_lo_o` and `sreg_hi_o` always show those two halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instck_en_i | input | 1 | One-cycle instruction-clock pulse feeding the divider |
| ctl_wr_i | input | 1 | Write strobe for the clock-select field |
| ctl_rate_i | input | 2 | Clock select: 00 external, 01 /2, 10 /4, 11 /8 |
| wr_lo_i | input | 1 | Write strobe for register bits 3..0 |
| wr_hi_i | input | 1 | Write strobe for register bits 7..4 |
| wdata_i | input | 4 | Nibble to write |
| start_i | input | 1 | Transfer start strobe |
| flag_clr_i | input | 1 | Clears the completion flag |
| sreg_lo_o | output | 4 | Register bits 3..0 |
| sreg_hi_o | output | 4 | Register bits 7..4 |
| done_o | output | 1 | Transfer completion flag and interrupt request |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Internally generated shift clock |
| sck_oe_o | output | 1 | Clock pin drive enable, 1 in internal mode |
| sin_i | input | 1 | Serial data in |
| sout_o | output | 1 | Serial data out |

## Verification
Two events can land in the same clock cycle: setting the completion flag on the eighth rising edge, and a software clear of that flag. The bench uses its reference model's bit count, phase and divider state to find the cycle just before the final rising edge, and asserts `flag_clr_i` for that one cycle. The case passes when `done_o` reads 1 on the next cycle and stays 1 until a later clear. A second same-cycle case is a start, a rate write and a register write issued in the middle of a transfer. It passes when the pulse count, the phase length and the received byte all match those of an undisturbed transfer.

// File: rtl/sio_pkg.sv
package sio_pkg;
    // Clock-select field codes
    typedef enum logic [1:0] {
        RATE_EXT  = 2'b00,
        RATE_DIV2 = 2'b01,
        RATE_DIV4 = 2'b10,
        RATE_DIV8 = 2'b11
    } rate_e;

    // Shift-clock edge strobes, one system-clock cycle wide
    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_edge_t;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
    import sio_pkg::*;
#(
    parameter int DIV_LOG_MAX = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       instck_en,
    input  rate_e      rate,
    output logic       sck,
    output sclk_edge_t edges
);
    localparam int TMR_W = (DIV_LOG_MAX > 1) ? DIV_LOG_MAX - 1 : 1;

    typedef struct packed {
        logic             sck;
        logic [TMR_W-1:0] tmr;
    } gen_st_t;

    gen_st_t          st_d, st_q;
    logic [TMR_W-1:0] lim;
    logic             hit;

    always_comb begin
        // phase length in instruction-clock pulses is 2^(code-1)
        if (rate == RATE_EXT) begin
            lim = '0;
        end else begin
            lim = TMR_W'((1 << (int'(rate) - 1)) - 1);
        end
        hit        = run && instck_en && (st_q.tmr == lim);
        edges.fall = hit && st_q.sck;
        edges.rise = hit && !st_q.sck;

        st_d = st_q;
        if (!run) begin
            st_d.sck = 1'b1;
            st_d.tmr = '0;
        end else if (instck_en) begin
            if (hit) begin
                st_d.tmr = '0;
                st_d.sck = !st_q.sck;
            end else begin
                st_d.tmr = st_q.tmr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sck <= 1'b1;
            st_q.tmr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck = st_q.sck;
endmodule

// File: rtl/sio_extsync.sv
module sio_extsync
    import sio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_in,
    output sclk_edge_t edges
);
    // chain_q[STAGES-1:0] are synchronizer flops, chain_q[STAGES] the previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d    = {chain_q[STAGES-1:0], sck_in};
        edges.rise = chain_q[STAGES-1] && !chain_q[STAGES];
        edges.fall = !chain_q[STAGES-1] && chain_q[STAGES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end
endmodule

// File: rtl/sio_core.sv
module sio_core
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              flag_clr,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_rate,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W/2-1:0] wdata,
    input  logic              sin,
    input  sclk_edge_t        edges,
    output logic [DATA_W-1:0] sreg,
    output logic              sout,
    output logic              busy,
    output logic              done,
    output rate_e             rate
);
    localparam int NIB_W = DATA_W / 2;
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sreg;
        logic              sout;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              done;
        rate_e             rate;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     last_rise;
    logic     accept_start;

    always_comb begin
        st_d         = st_q;
        accept_start = start && !st_q.busy;
        last_rise    = st_q.busy && edges.rise && (st_q.cnt == LAST);

        if (!st_q.busy) begin
            if (ctl_wr) st_d.rate = rate_e'(ctl_rate);
            if (wr_lo)  st_d.sreg[NIB_W-1:0] = wdata;
            if (wr_hi)  st_d.sreg[DATA_W-1:NIB_W] = wdata;
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
            end
        end else begin
            if (edges.fall) st_d.sout = st_q.sreg[0];
            if (edges.rise) begin
                st_d.sreg = {sin, st_q.sreg[DATA_W-1:1]};
                st_d.cnt  = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) st_d.busy = 1'b0;
            end
        end

        // setting on completion outranks a clear in the same cycle
        if (last_rise) begin
            st_d.done = 1'b1;
        end else if (flag_clr || accept_start) begin
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sreg <= '0;
            st_q.sout <= 1'b1;
            st_q.cnt  <= '0;
            st_q.busy <= 1'b0;
            st_q.done <= 1'b0;
            st_q.rate <= RATE_EXT;
        end else begin
            st_q <= st_d;
        end
    end

    assign sreg = st_q.sreg;
    assign sout = st_q.sout;
    assign busy = st_q.busy;
    assign done = st_q.done;
    assign rate = st_q.rate;
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_LOG_MAX = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instck_en_i,
    input  logic                ctl_wr_i,
    input  logic [1:0]          ctl_rate_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [DATA_W/2-1:0] wdata_i,
    input  logic                start_i,
    input  logic                flag_clr_i,
    output logic [DATA_W/2-1:0] sreg_lo_o,
    output logic [DATA_W/2-1:0] sreg_hi_o,
    output logic                done_o,
    input  logic                sck_i,
    output logic                sck_o,
    output logic                sck_oe_o,
    input  logic                sin_i,
    output logic                sout_o
);
    localparam int NIB_W = DATA_W / 2;

    logic              busy_w;
    logic              int_mode;
    logic              int_run;
    logic              int_sck;
    rate_e             rate_w;
    sclk_edge_t        int_edges;
    sclk_edge_t        ext_edges;
    sclk_edge_t        sel_edges;
    logic [DATA_W-1:0] sreg_w;

    assign int_mode = (rate_w != RATE_EXT);
    assign int_run  = busy_w && int_mode;

    sio_clkgen #(
        .DIV_LOG_MAX(DIV_LOG_MAX)
    ) clkgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (int_run),
        .instck_en(instck_en_i),
        .rate     (rate_w),
        .sck      (int_sck),
        .edges    (int_edges)
    );

    sio_extsync #(
        .STAGES(SYNC_STAGES)
    ) extsync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_in(sck_i),
        .edges (ext_edges)
    );

    always_comb begin
        if (int_mode) begin
            sel_edges = int_edges;
        end else if (busy_w) begin
            sel_edges = ext_edges;
        end else begin
            sel_edges = '0;
        end
    end

    sio_core #(
        .DATA_W(DATA_W)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .flag_clr(flag_clr_i),
        .ctl_wr  (ctl_wr_i),
        .ctl_rate(ctl_rate_i),
        .wr_lo   (wr_lo_i),
        .wr_hi   (wr_hi_i),
        .wdata   (wdata_i),
        .sin     (sin_i),
        .edges   (sel_edges),
        .sreg    (sreg_w),
        .sout    (sout_o),
        .busy    (busy_w),
        .done    (done_o),
        .rate    (rate_w)
    );

    assign sreg_lo_o = sreg_w[NIB_W-1:0];
    assign sreg_hi_o = sreg_w[DATA_W-1:NIB_W];
    assign sck_o     = int_mode ? int_sck : 1'b1;
    assign sck_oe_o  = int_mode;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       sck,
    input logic       sck_oe,
    input logic       sout,
    input logic       start,
    input logic       flag_clr,
    input logic [1:0] rate
);
    // R3: output data moves only with a falling internal shift clock
    p_sout_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && !$stable(sout)) |-> $fell(sck));

    // R5: clock line idles high outside a transfer
    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck);

    // R8: end of a transfer leaves the flag set
    p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: the flag drops only after a clear or a start
    p_done_clear_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(flag_clr || start));

    // R9: a clear coinciding with the last edge loses
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(flag_clr)) |-> done);

    // R10: clock select frozen during a transfer
    p_rate_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rate));
endmodule

bind sio_port sio_port_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_w),
    .done    (done_o),
    .sck     (sck_o),
    .sck_oe  (sck_oe_o),
    .sout    (sout_o),
    .start   (start_i),
    .flag_clr(flag_clr_i),
    .rate    (rate_w)
);

// File: tb/sio_port_tb_top.sv
module sio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instck_en = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [1:0] ctl_rate = 2'b00;
    logic       wr_lo = 1'b0, wr_hi = 1'b0;
    logic [3:0] wdata = 4'h0;
    logic       start = 1'b0, flag_clr = 1'b0;
    logic [3:0] sreg_lo, sreg_hi;
    logic       done_o, sck_i = 1'b1, sck_o, sck_oe, sin = 1'b0, sout_o;

    int n_checks = 0;
    int n_fail = 0;
    int inst_per = 1;
    int inst_cnt = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sio_port dut_i (
        .clk(clk), .rst_n(rst_n), .instck_en_i(instck_en), .ctl_wr_i(ctl_wr),
        .ctl_rate_i(ctl_rate), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata),
        .start_i(start), .flag_clr_i(flag_clr), .sreg_lo_o(sreg_lo), .sreg_hi_o(sreg_hi),
        .done_o(done_o), .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe),
        .sin_i(sin), .sout_o(sout_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // instruction clock enable, one pulse every inst_per cycles
    always @(negedge clk) begin
        instck_en <= (inst_cnt == 0);
        inst_cnt  <= (inst_cnt + 1 >= inst_per) ? 0 : inst_cnt + 1;
    end

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_sreg;
    bit m_sout, m_sck, m_busy, m_done, h1, h2, h3, mr, mf, fin;
    int m_tmr, m_cnt, m_rate, half;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sreg = 8'h00; m_sout = 1; m_sck = 1; m_tmr = 0; m_cnt = 0;
            m_busy = 0; m_done = 0; m_rate = 0; h1 = 1; h2 = 1; h3 = 1;
        end else begin
            mr = 0; mf = 0;
            half = (m_rate == 0) ? 1 : (1 << (m_rate - 1));
            if (m_busy) begin
                if (m_rate == 0) begin
                    mr = h2 && !h3;
                    mf = !h2 && h3;
                end else if (instck_en && m_tmr == half - 1) begin
                    mr = !m_sck;
                    mf = m_sck;
                end
            end
            fin = m_busy && mr && (m_cnt == 7);
            if (fin) m_done = 1;
            else if (flag_clr || (start && !m_busy)) m_done = 0;
            if (m_busy && m_rate != 0) begin
                if (instck_en) begin
                    if (m_tmr == half - 1) begin m_tmr = 0; m_sck = !m_sck; end
                    else m_tmr++;
                end
            end else begin
                m_sck = 1; m_tmr = 0;
            end
            if (!m_busy) begin
                if (ctl_wr) m_rate = int'(ctl_rate);
                if (wr_lo) m_sreg[3:0] = wdata;
                if (wr_hi) m_sreg[7:4] = wdata;
                if (start) begin m_busy = 1; m_cnt = 0; end
            end else begin
                if (mf) m_sout = m_sreg[0];
                if (mr) begin
                    m_sreg = {sin, m_sreg[7:1]};
                    m_cnt++;
                    if (fin) m_busy = 0;
                end
            end
            h3 = h2; h2 = h1; h1 = sck_i;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            check(sck_o == ((m_rate != 0) ? m_sck : 1'b1), "R5", "model sck",
                  int'(sck_o), int'((m_rate != 0) ? m_sck : 1'b1));
            check(sout_o == m_sout, "R3", "model sout", int'(sout_o), int'(m_sout));
            check({sreg_hi, sreg_lo} == m_sreg, "R4", "model sreg",
                  int'({sreg_hi, sreg_lo}), int'(m_sreg));
            check(done_o == m_done, "R8", "model done", int'(done_o), int'(m_done));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic set_rate(input logic [1:0] r);
        @(negedge clk); ctl_wr = 1; ctl_rate = r;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); wr_lo = 1; wdata = b[3:0];
        @(negedge clk); wr_lo = 0; wr_hi = 1; wdata = b[7:4];
        @(negedge clk); wr_hi = 0;
    endtask

    task automatic run_int(input logic [7:0] tx, input logic [7:0] rx, input int rate,
                           input int per, input bit clr_end, input bit meddle);
        logic [7:0] cap = 8'h00;
        int nr = 0, lowc = 0, lo_min = 100000, lo_max = 0, cyc = 0, stray = 0;
        int hp = 1 << (rate - 1);
        bit prev;
        inst_per = per;
        set_rate(2'(rate));
        write_byte(tx);
        @(negedge clk); sin = rx[0]; start = 1;
        @(negedge clk); start = 0;
        check(done_o == 1'b0, "R8", "flag after start", int'(done_o), 0);
        prev = sck_o;
        while (nr < 8 && cyc < 5000) begin
            if (meddle && cyc == 6) begin
                start = 1; ctl_wr = 1; ctl_rate = 2'b01; wr_lo = 1; wdata = 4'hF;
            end else begin
                start = 0; ctl_wr = 0; wr_lo = 0;
            end
            flag_clr = clr_end && m_busy && m_cnt == 7 && !m_sck && (m_tmr == hp - 1);
            @(negedge clk);
            cyc++;
            if (!sck_o) lowc++;
            if (!prev && sck_o) begin
                cap[nr] = sout_o;
                nr++;
                if (nr < 8) sin = rx[nr];
                if (lowc < lo_min) lo_min = lowc;
                if (lowc > lo_max) lo_max = lowc;
                lowc = 0;
            end
            prev = sck_o;
        end
        start = 0; ctl_wr = 0; wr_lo = 0; flag_clr = 0;
        check(sck_oe == 1'b1, "R7", "drive enable internal", int'(sck_oe), 1);
        check(done_o == 1'b1, clr_end ? "R9" : "R8", "flag at end", int'(done_o), 1);
        check(cap == tx, "R2", "transmitted byte", int'(cap), int'(tx));
        check({sreg_hi, sreg_lo} == rx, meddle ? "R10" : "R4", "received byte",
              int'({sreg_hi, sreg_lo}), int'(rx));
        check(lo_min == hp * per && lo_max == hp * per, meddle ? "R10" : "R6",
              "low phase cycles", lo_max, hp * per);
        repeat (4 * hp * per + 4) begin
            @(negedge clk);
            if (!sck_o) stray++;
        end
        check(nr == 8 && stray == 0, "R5", "pulse count / idle high", nr * 100 + stray, 800);
    endtask

    task automatic ext_xfer(input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] cap = 8'h00;
        set_rate(2'b00);
        write_byte(tx);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        check(sck_oe == 1'b0, "R7", "drive enable external", int'(sck_oe), 0);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sck_i = 0; sin = rx[i];
            repeat (4) @(negedge clk);
            cap[i] = sout_o;
            sck_i = 1;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(cap == tx, "R7", "external transmitted byte", int'(cap), int'(tx));
        check({sreg_hi, sreg_lo} == rx, "R7", "external received byte",
              int'({sreg_hi, sreg_lo}), int'(rx));
        check(done_o == 1'b1, "R7", "external flag", int'(done_o), 1);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        check({sreg_hi, sreg_lo} == 8'h00, "R1", "reset register", int'({sreg_hi, sreg_lo}), 0);
        check(done_o == 1'b0, "R1", "reset flag", int'(done_o), 0);
        check(sck_o == 1'b1 && sck_oe == 1'b0, "R1", "reset clock pin",
              int'({sck_o, sck_oe}), 2);
        check(sout_o == 1'b1, "R1", "reset sout", int'(sout_o), 1);
        rst_n = 1; cmp_en = 1;

        write_byte(8'h5A);
        @(negedge clk);
        check(sreg_lo == 4'hA, "R11", "low nibble", int'(sreg_lo), 'hA);
        check(sreg_hi == 4'h5, "R11", "high nibble", int'(sreg_hi), 'h5);

        run_int(8'h5A, 8'hC3, 1, 1, 0, 0);
        run_int(8'h96, 8'h3C, 2, 2, 0, 0);
        run_int(8'hF0, 8'h81, 3, 1, 0, 0);

        repeat (10) @(negedge clk);
        check(done_o == 1'b1, "R8", "flag held while idle", int'(done_o), 1);
        flag_clr = 1; @(negedge clk); flag_clr = 0;
        check(done_o == 1'b0, "R8", "flag cleared", int'(done_o), 0);

        run_int(8'hA5, 8'h5A, 1, 1, 1, 0);
        @(negedge clk);
        check(done_o == 1'b1, "R9", "flag survives coincident clear", int'(done_o), 1);

        run_int(8'h3C, 8'hE7, 3, 1, 0, 1);
        ext_xfer(8'hC5, 8'h2B);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule